// File: doc/BRIEF.md
# Four-Channel DAC Register Bank with Load Control

This block is the digital core behind a four-channel, 16-bit voltage DAC. A serial front end hands it a complete 24-bit command word with a one-cycle strobe. The block decodes the word and keeps the register set for each channel: a pending input code, the live converter code, a coarse gain, a fine gain and an offset. It also keeps one shared configuration register that drives a two-pin general-purpose port and two control flags. A load pin chooses whether a data write reaches the converter at once or waits, and a clear pin forces every converter code to zero.

The live codes leave the block in the form the converter expects, which is straight binary. When the coding pin selects two's complement, the sign bit is inverted on the way out. As a result, a zeroed register means 0 V in two's complement and negative full scale in straight binary. A read command picks one register. Its contents are shown, zero-extended, on the readback word until another read command arrives.

Load control runs on a three-state machine that is updated every clock from the two pins:

- HOLD: load pin high.
- RUN: load pin low.
- CLEAR: clear pin low.

The transitions are:

- any→CLEAR when the clear pin is low.
- CLEAR→HOLD or CLEAR→RUN when clear is released, following the load pin. Neither copies anything.
- RUN→HOLD on a rising load pin.
- HOLD→RUN on a falling load pin. This is the transition that copies every input register into its live register.

The reset state is HOLD.

Top module: `dac_regbank`

## Requirements
- R1: After reset, every input register and live register is 0x0000. The configuration register is all zero, so `gpio_oe`, `gpio_out`, `lgo_en` and `sdo_off` are 0. The readback selection is the configuration register.
- R2: Command bits, from MSB to LSB:
  - bit 23: read flag
  - bit 22: must be 0
  - bits 21:19: register select (000 config/command, 010 data, 011 coarse gain, 100 fine gain, 101 offset)
  - bits 18:16: address
  - bits 15:0: data

  A strobed word with bit 22 set, or with a select of 001, 110 or 111, changes nothing.
- R3: A data write made while the load pin is low and clear is high updates that channel's input register and live register. The change is visible one clock after the strobe.
- R4: A data write made while the load pin is high updates only the input register. One clock after the load pin is sampled falling from high, every live register holds its input register. If a data write arrives in that same cycle, its new value is the one copied. While the load pin stays high, the live registers do not change except through a clear.
- R5: Addresses 000 to 011 select channels 0 to 3. Address 100 writes all four channels. Addresses 101 to 111 leave every per-channel register unchanged.
- R6: While the clear pin is low, every live register is 0x0000 one clock later and stays there. This overrides the load pin and data writes, but input registers still take writes. After release, the live registers stay 0x0000 until a load or a direct write.
- R7: `dac_codes[16*i+15:16*i]` shows channel i's live register when `bin_sel`=1. When `bin_sel`=0 it shows the live register XOR 0x8000.
- R8: Under select 000, the addresses act as follows:
  - 100: zeroes every live register.
  - 101: copies every input register into its live register.
  - 000, 010, 011, 110 and 111: change nothing.
- R9: Select 000 with address 001 writes the configuration register:
  - bit 5: `lgo_en`
  - bit 4: direction of pin 1
  - bit 3: value of pin 1
  - bit 2: direction of pin 0
  - bit 1: value of pin 0
  - bit 0: `sdo_off`

  A direction bit of 1 drives `gpio_oe` high for that pin, and `gpio_out` carries the value bit.
- R10: A value bit written together with direction 0 is stored as 0, so `gpio_out` is 0 for that pin. Readback of the configuration register returns `gpio_in` in the value position of each pin whose direction is 0.
- R11: Coarse gain is stored in 2 bits, and a written code of 11 is stored as 00. Fine gain is stored in 6 bits (data 5:0) and offset in 8 bits (data 7:0).
- R12: A read command (bit 23 = 1, bit 22 = 0) changes no register. From the next clock it sets `rb_word` to the zero-extended contents of the selected register, as follows:
  - data: the input register.
  - per-channel selects with address 100 to 111: 0.
  - select 000: the configuration layout of R9, for any address.
  - reserved selects: 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe marking a complete command word |
| cmd_word | input | 24 | Command word, layout per R2 |
| ldac_n | input | 1 | Load pin; low = immediate update, falling edge = load all |
| clr_n | input | 1 | Active-low level clear, sampled each clock |
| bin_sel | input | 1 | Coding select; 1 straight binary, 0 two's complement |
| gpio_in | input | 2 | Live levels of the two port pins |
| dac_codes | output | 64 | Four converter codes, channel i at bits 16i+15:16i |
| gpio_out | output | 2 | Port pin drive values |
| gpio_oe | output | 2 | Port pin output enables |
| lgo_en | output | 1 | Local-ground-offset enable flag |
| sdo_off | output | 1 | Serial-out disable flag |
| rb_word | output | 16 | Readback contents of the selected register |

## Verification
The properties assume that `ldac_n` and `clr_n` are already synchronous to `clk` and hold steady between edges. They also assume that `cmd_valid` is a single-cycle pulse that never overlaps another word's strobe. The load-copy property further assumes that no command is strobed in the cycle where the load pin falls. The bench drives every input only on the falling clock edge and pulses the strobe for exactly one cycle per word. Its random stream changes the load and clear pins by cycle-level toggles, so the single-edge conditions above are always met.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;
    localparam int AW  = 3;
    localparam int CGW = 2;
    localparam int FGW = 6;
    localparam int OFW = 8;
    localparam int FNW = 6;

    localparam logic [2:0] SEL_FUNC   = 3'b000;
    localparam logic [2:0] SEL_DATA   = 3'b010;
    localparam logic [2:0] SEL_COARSE = 3'b011;
    localparam logic [2:0] SEL_FINE   = 3'b100;
    localparam logic [2:0] SEL_OFFS   = 3'b101;

    localparam logic [2:0] FN_CFG   = 3'b001;
    localparam logic [2:0] FN_SWCLR = 3'b100;
    localparam logic [2:0] FN_SWLD  = 3'b101;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_RUN   = 2'd1,
        ST_CLEAR = 2'd2
    } upd_state_e;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import dac_regbank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input  logic              cmd_valid,
    input  logic [DW+7:0]     cmd_word,
    output logic [NCH-1:0]    data_we,
    output logic [NCH-1:0]    coarse_we,
    output logic [NCH-1:0]    fine_we,
    output logic [NCH-1:0]    offs_we,
    output logic              cfg_we,
    output logic              sw_clear,
    output logic              sw_load,
    output logic              rd_we,
    output logic [2:0]        rd_sel,
    output logic [AW-1:0]     rd_addr,
    output logic [DW-1:0]     wdata
);
    localparam int CW = DW + 8;

    logic          word_ok;
    logic          wr;
    logic [2:0]    sel;
    logic [AW-1:0] addr;

    assign word_ok = cmd_valid && !cmd_word[CW-2];
    assign wr      = word_ok && !cmd_word[CW-1];
    assign sel     = cmd_word[CW-3:CW-5];
    assign addr    = cmd_word[CW-6:CW-8];
    assign wdata   = cmd_word[DW-1:0];

    for (genvar i = 0; i < NCH; i++) begin : g_hit
        logic hit;
        assign hit          = (addr == AW'(i)) || (addr == AW'(NCH));
        assign data_we[i]   = wr && hit && (sel == SEL_DATA);
        assign coarse_we[i] = wr && hit && (sel == SEL_COARSE);
        assign fine_we[i]   = wr && hit && (sel == SEL_FINE);
        assign offs_we[i]   = wr && hit && (sel == SEL_OFFS);
    end

    assign cfg_we   = wr && (sel == SEL_FUNC) && (addr == FN_CFG);
    assign sw_clear = wr && (sel == SEL_FUNC) && (addr == FN_SWCLR);
    assign sw_load  = wr && (sel == SEL_FUNC) && (addr == FN_SWLD);
    assign rd_we    = word_ok && cmd_word[CW-1];
    assign rd_sel   = sel;
    assign rd_addr  = addr;
endmodule

// File: rtl/dac_update_fsm.sv
module dac_update_fsm
    import dac_regbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ldac_n,
    input  logic clr_n,
    input  logic sw_clear,
    input  logic sw_load,
    output logic load_all,
    output logic force_clear,
    output logic direct_en
);
    upd_state_e state_q, state_d;

    always_comb begin
        if (!clr_n)      state_d = ST_CLEAR;
        else if (ldac_n) state_d = ST_HOLD;
        else             state_d = ST_RUN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        force_clear = !clr_n || sw_clear;
        direct_en   = clr_n && !ldac_n;
        load_all    = 1'b0;
        unique case (state_q)
            ST_HOLD:  load_all = clr_n && (!ldac_n || sw_load);
            ST_RUN:   load_all = clr_n && sw_load;
            ST_CLEAR: load_all = clr_n && sw_load;
            default:  load_all = clr_n && sw_load;
        endcase
    end
endmodule

// File: rtl/dac_chan.sv
module dac_chan
    import dac_regbank_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           data_we,
    input  logic           coarse_we,
    input  logic           fine_we,
    input  logic           offs_we,
    input  logic [DW-1:0]  wdata,
    input  logic           load_all,
    input  logic           force_clear,
    input  logic           direct_en,
    output logic [DW-1:0]  in_q,
    output logic [DW-1:0]  dac_q,
    output logic [CGW-1:0] coarse_q,
    output logic [FGW-1:0] fine_q,
    output logic [OFW-1:0] offs_q
);
    logic [DW-1:0] in_d;
    assign in_d = data_we ? wdata : in_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q     <= '0;
            dac_q    <= '0;
            coarse_q <= '0;
            fine_q   <= '0;
            offs_q   <= '0;
        end else begin
            in_q <= in_d;
            if (force_clear)                dac_q <= '0;
            else if (load_all)              dac_q <= in_d;
            else if (data_we && direct_en)  dac_q <= wdata;
            if (coarse_we) coarse_q <= (&wdata[CGW-1:0]) ? '0 : wdata[CGW-1:0];
            if (fine_we)   fine_q   <= wdata[FGW-1:0];
            if (offs_we)   offs_q   <= wdata[OFW-1:0];
        end
    end
endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
    import dac_regbank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [DW+7:0]     cmd_word,
    input  logic              ldac_n,
    input  logic              clr_n,
    input  logic              bin_sel,
    input  logic [1:0]        gpio_in,
    output logic [NCH*DW-1:0] dac_codes,
    output logic [1:0]        gpio_out,
    output logic [1:0]        gpio_oe,
    output logic              lgo_en,
    output logic              sdo_off,
    output logic [DW-1:0]     rb_word
);
    logic [NCH-1:0] data_we, coarse_we, fine_we, offs_we;
    logic           cfg_we, sw_clear, sw_load, rd_we;
    logic [2:0]     rd_sel, rd_sel_q;
    logic [AW-1:0]  rd_addr, rd_addr_q;
    logic [DW-1:0]  wdata;
    logic           load_all, force_clear, direct_en;

    logic [NCH-1:0][DW-1:0]  in_a;
    logic [NCH-1:0][DW-1:0]  dac_a;
    logic [NCH-1:0][CGW-1:0] co_a;
    logic [NCH-1:0][FGW-1:0] fi_a;
    logic [NCH-1:0][OFW-1:0] of_a;

    logic       lgo_q, sdo_q;
    logic [1:0] dir_q, val_q, pin_v;

    dac_cmd_decode #(.NCH(NCH), .DW(DW)) u_dec (
        .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .data_we(data_we), .coarse_we(coarse_we), .fine_we(fine_we), .offs_we(offs_we),
        .cfg_we(cfg_we), .sw_clear(sw_clear), .sw_load(sw_load),
        .rd_we(rd_we), .rd_sel(rd_sel), .rd_addr(rd_addr), .wdata(wdata)
    );

    dac_update_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ldac_n(ldac_n), .clr_n(clr_n),
        .sw_clear(sw_clear), .sw_load(sw_load),
        .load_all(load_all), .force_clear(force_clear), .direct_en(direct_en)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dac_chan #(.DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .data_we(data_we[i]), .coarse_we(coarse_we[i]),
            .fine_we(fine_we[i]), .offs_we(offs_we[i]), .wdata(wdata),
            .load_all(load_all), .force_clear(force_clear), .direct_en(direct_en),
            .in_q(in_a[i]), .dac_q(dac_a[i]),
            .coarse_q(co_a[i]), .fine_q(fi_a[i]), .offs_q(of_a[i])
        );
        assign dac_codes[i*DW +: DW] = dac_a[i] ^ {~bin_sel, {(DW-1){1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lgo_q     <= 1'b0;
            dir_q     <= '0;
            val_q     <= '0;
            sdo_q     <= 1'b0;
            rd_sel_q  <= SEL_FUNC;
            rd_addr_q <= '0;
        end else begin
            if (cfg_we) begin
                lgo_q <= wdata[5];
                dir_q <= {wdata[4], wdata[2]};
                val_q <= {wdata[4] & wdata[3], wdata[2] & wdata[1]};
                sdo_q <= wdata[0];
            end
            if (rd_we) begin
                rd_sel_q  <= rd_sel;
                rd_addr_q <= rd_addr;
            end
        end
    end

    assign pin_v = val_q | (~dir_q & gpio_in);

    always_comb begin
        rb_word = '0;
        if (rd_sel_q == SEL_FUNC) begin
            rb_word[FNW-1:0] = {lgo_q, dir_q[1], pin_v[1], dir_q[0], pin_v[0], sdo_q};
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (rd_addr_q == AW'(i)) begin
                    case (rd_sel_q)
                        SEL_DATA:   rb_word = in_a[i];
                        SEL_COARSE: rb_word = DW'(co_a[i]);
                        SEL_FINE:   rb_word = DW'(fi_a[i]);
                        SEL_OFFS:   rb_word = DW'(of_a[i]);
                        default:    rb_word = '0;
                    endcase
                end
            end
        end
    end

    assign gpio_out = val_q;
    assign gpio_oe  = dir_q;
    assign lgo_en   = lgo_q;
    assign sdo_off  = sdo_q;
endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk
    import dac_regbank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clr_n,
    input logic                    ldac_n,
    input logic                    cmd_valid,
    input logic                    sw_load,
    input logic                    sw_clear,
    input logic [NCH-1:0][DW-1:0]  dac_a,
    input logic [NCH-1:0][DW-1:0]  in_a,
    input logic [NCH-1:0][CGW-1:0] co_a,
    input logic [1:0]              gpio_oe,
    input logic [1:0]              gpio_out
);
    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (dac_a == '0));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ldac_n && !sw_load && !sw_clear) |=> $stable(dac_a));

    // R4
    fall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ldac_n) && clr_n && $past(clr_n) && !cmd_valid) |=> (dac_a == $past(in_a)));

    // R10
    gpio_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gpio_out & ~gpio_oe) == 2'b00));

    for (genvar i = 0; i < NCH; i++) begin : g_co
        // R11
        coarse_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            co_a[i] != 2'b11);
    end
endmodule

bind dac_regbank dac_regbank_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ldac_n(ldac_n),
    .cmd_valid(cmd_valid), .sw_load(sw_load), .sw_clear(sw_clear),
    .dac_a(dac_a), .in_a(in_a), .co_a(co_a),
    .gpio_oe(gpio_oe), .gpio_out(gpio_out)
);

// File: tb/dac_regbank_bench.sv
module dac_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [23:0] cmd_word = '0;
    logic        ldac_n = 1'b1;
    logic        clr_n = 1'b1;
    logic        bin_sel = 1'b0;
    logic [1:0]  gpio_in = 2'b00;
    logic [63:0] dac_codes;
    logic [1:0]  gpio_out, gpio_oe;
    logic        lgo_en, sdo_off;
    logic [15:0] rb_word;

    int n_chk = 0;
    int n_err = 0;

    logic [15:0] m_in [4];
    logic [15:0] m_dac [4];
    logic [1:0]  m_co [4];
    logic [5:0]  m_fi [4];
    logic [7:0]  m_of [4];
    logic        m_lgo, m_sdo;
    logic [1:0]  m_dir, m_val;
    logic [2:0]  m_rsel, m_raddr;
    int          m_st;

    dac_regbank u_dac_regbank (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .ldac_n(ldac_n), .clr_n(clr_n), .bin_sel(bin_sel), .gpio_in(gpio_in),
        .dac_codes(dac_codes), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .lgo_en(lgo_en), .sdo_off(sdo_off), .rb_word(rb_word)
    );

    always #5 clk = ~clk;

    function automatic logic [23:0] mk(input logic rd, input logic [2:0] sel,
                                       input logic [2:0] a, input logic [15:0] d);
        return {rd, 1'b0, sel, a, d};
    endfunction

    function automatic logic [63:0] exp_codes();
        logic [63:0] v;
        for (int c = 0; c < 4; c++) v[c*16 +: 16] = m_dac[c] ^ (bin_sel ? 16'h0000 : 16'h8000);
        return v;
    endfunction

    function automatic logic [15:0] exp_rb();
        logic [1:0] pv;
        pv = m_val | (~m_dir & gpio_in);
        case (m_rsel)
            3'b000: return {10'b0, m_lgo, m_dir[1], pv[1], m_dir[0], pv[0], m_sdo};
            3'b010: return (m_raddr < 4) ? m_in[m_raddr[1:0]] : 16'h0;
            3'b011: return (m_raddr < 4) ? {14'b0, m_co[m_raddr[1:0]]} : 16'h0;
            3'b100: return (m_raddr < 4) ? {10'b0, m_fi[m_raddr[1:0]]} : 16'h0;
            3'b101: return (m_raddr < 4) ? {8'b0, m_of[m_raddr[1:0]]} : 16'h0;
            default: return 16'h0;
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_in[c] = '0; m_dac[c] = '0; m_co[c] = '0; m_fi[c] = '0; m_of[c] = '0;
        end
        m_lgo = 0; m_sdo = 0; m_dir = 0; m_val = 0; m_rsel = 0; m_raddr = 0; m_st = 0;
    endtask

    task automatic model_step(input logic v, input logic [23:0] w);
        logic ok, wr, swc, swl, force_c, load, dir_ok, hit;
        logic [2:0] sel, a;
        logic [15:0] d, nin;
        ok = v && !w[22]; wr = ok && !w[23];
        sel = w[21:19]; a = w[18:16]; d = w[15:0];
        swc = wr && sel == 3'b000 && a == 3'd4;
        swl = wr && sel == 3'b000 && a == 3'd5;
        force_c = !clr_n || swc;
        load = clr_n && ((m_st == 0 && !ldac_n) || swl);
        dir_ok = clr_n && !ldac_n;
        for (int c = 0; c < 4; c++) begin
            hit = (a == 3'(c)) || (a == 3'd4);
            nin = (wr && sel == 3'b010 && hit) ? d : m_in[c];
            if (force_c) m_dac[c] = '0;
            else if (load) m_dac[c] = nin;
            else if (wr && sel == 3'b010 && hit && dir_ok) m_dac[c] = d;
            m_in[c] = nin;
            if (wr && hit && sel == 3'b011) m_co[c] = (d[1:0] == 2'b11) ? 2'b00 : d[1:0];
            if (wr && hit && sel == 3'b100) m_fi[c] = d[5:0];
            if (wr && hit && sel == 3'b101) m_of[c] = d[7:0];
        end
        if (wr && sel == 3'b000 && a == 3'd1) begin
            m_lgo = d[5]; m_dir = {d[4], d[2]}; m_val = {d[4] & d[3], d[2] & d[1]}; m_sdo = d[0];
        end
        if (ok && w[23]) begin m_rsel = sel; m_raddr = a; end
        m_st = !clr_n ? 2 : (ldac_n ? 0 : 1);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " dac_codes"}, dac_codes, exp_codes());
        chk({tag, " gpio"}, {60'b0, gpio_oe, gpio_out}, {60'b0, m_dir, m_val});
        chk({tag, " flags"}, {62'b0, lgo_en, sdo_off}, {62'b0, m_lgo, m_sdo});
        chk({tag, " rb_word"}, {48'b0, rb_word}, {48'b0, exp_rb()});
    endtask

    task automatic step(input logic v, input logic [23:0] w);
        cmd_valid = v; cmd_word = w;
        model_step(v, w);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state, two's complement coding
        chk("R1 reset codes", dac_codes, {4{16'h8000}});
        chk("R1 reset port", {60'b0, gpio_oe, gpio_out}, 64'h0);
        compare_all("R1");
        // R7 straight binary coding of a zeroed register
        bin_sel = 1'b1; @(negedge clk);
        chk("R7 binary zero", dac_codes, 64'h0);
        // R3 immediate update
        ldac_n = 1'b0; step(1'b0, '0);
        step(1'b1, mk(0, 3'b010, 3'd1, 16'h1234));
        chk("R3 direct write", dac_codes, {16'h0, 16'h0, 16'h1234, 16'h0});
        compare_all("R3");
        // R4 buffered write then load on falling edge
        ldac_n = 1'b1; step(1'b0, '0);
        step(1'b1, mk(0, 3'b010, 3'd2, 16'hBEEF));
        chk("R4 held", dac_codes, {16'h0, 16'h0, 16'h1234, 16'h0});
        ldac_n = 1'b0; step(1'b0, '0);
        chk("R4 load all", dac_codes, {16'h0, 16'hBEEF, 16'h1234, 16'h0});
        compare_all("R4");
        // R5 broadcast and out-of-range address
        step(1'b1, mk(0, 3'b010, 3'd4, 16'h0F0F));
        chk("R5 broadcast", dac_codes, {4{16'h0F0F}});
        step(1'b1, mk(0, 3'b010, 3'd6, 16'h1111));
        chk("R5 ignored addr", dac_codes, {4{16'h0F0F}});
        // R7 two's complement view
        bin_sel = 1'b0; @(negedge clk);
        chk("R7 twos view", dac_codes, {4{16'h8F0F}});
        bin_sel = 1'b1;
        // R6 clear overrides direct write, input still written
        clr_n = 1'b0;
        step(1'b1, mk(0, 3'b010, 3'd0, 16'h5555));
        chk("R6 cleared", dac_codes, 64'h0);
        clr_n = 1'b1; step(1'b0, '0);
        step(1'b1, mk(1, 3'b010, 3'd0, 16'h0));
        chk("R6 still zero", dac_codes, 64'h0);
        chk("R6 input kept", {48'b0, rb_word}, 64'h5555);
        compare_all("R6");
        // R2 bit 22 set and reserved select ignored
        step(1'b1, mk(0, 3'b010, 3'd0, 16'h7777) | 24'h400000);
        step(1'b1, mk(0, 3'b001, 3'd0, 16'h7777));
        chk("R2 ignored", dac_codes, 64'h0);
        compare_all("R2");
        // R8 software load, then software clear, then NOP
        step(1'b1, mk(0, 3'b000, 3'd5, 16'h0));
        chk("R8 sw load", dac_codes, {16'h0F0F, 16'h0F0F, 16'h0F0F, 16'h5555});
        step(1'b1, mk(0, 3'b000, 3'd0, 16'hFFFF));
        chk("R8 nop", dac_codes, {16'h0F0F, 16'h0F0F, 16'h0F0F, 16'h5555});
        step(1'b1, mk(0, 3'b000, 3'd4, 16'h0));
        chk("R8 sw clear", dac_codes, 64'h0);
        // R9 configuration fields
        step(1'b1, mk(0, 3'b000, 3'd1, 16'h003F));
        chk("R9 cfg all", {60'b0, lgo_en, sdo_off, gpio_oe}, {60'b0, 2'b11, 2'b11});
        chk("R9 cfg out", {62'b0, gpio_out}, 64'h3);
        // R10 value bit ignored for input pin, live level on readback
        gpio_in = 2'b10;
        step(1'b1, mk(0, 3'b000, 3'd1, 16'h000E));
        chk("R10 pin drive", {60'b0, gpio_oe, gpio_out}, {60'b0, 2'b01, 2'b01});
        step(1'b1, mk(1, 3'b000, 3'd3, 16'h0));
        chk("R10 readback", {48'b0, rb_word}, 64'h000E);
        // R11 coarse 11 maps to 00, fine and offset widths
        step(1'b1, mk(0, 3'b011, 3'd0, 16'hFFFF));
        step(1'b1, mk(1, 3'b011, 3'd0, 16'h0));
        chk("R11 coarse 11", {48'b0, rb_word}, 64'h0);
        step(1'b1, mk(0, 3'b011, 3'd0, 16'h0002));
        chk("R11 coarse 10", {48'b0, rb_word}, 64'h2);
        step(1'b1, mk(0, 3'b100, 3'd3, 16'hFFFF));
        step(1'b1, mk(1, 3'b100, 3'd3, 16'h0));
        chk("R11 fine width", {48'b0, rb_word}, 64'h3F);
        step(1'b1, mk(0, 3'b101, 3'd4, 16'hABCD));
        step(1'b1, mk(1, 3'b101, 3'd2, 16'h0));
        chk("R11 offset width", {48'b0, rb_word}, 64'hCD);
        // R12 read leaves registers alone, reserved addresses read 0
        step(1'b1, mk(1, 3'b010, 3'd5, 16'hFFFF));
        chk("R12 reserved addr", {48'b0, rb_word}, 64'h0);
        chk("R12 no change", dac_codes, 64'h0);
        compare_all("R12");
        // Random stream mixed with the model
        for (int n = 0; n < 4000; n++) begin
            logic v;
            logic [23:0] w;
            logic [2:0] sel;
            v = ($urandom % 2) == 0;
            case ($urandom % 8)
                0: sel = 3'b000; 1: sel = 3'b001; 2, 3: sel = 3'b010; 4: sel = 3'b011;
                5: sel = 3'b100; 6: sel = 3'b101; default: sel = 3'($urandom % 8);
            endcase
            w = mk(($urandom % 6) == 0, sel, 3'($urandom % 8), 16'($urandom));
            if (($urandom % 16) == 0) w[22] = 1'b1;
            if (($urandom % 8) == 0) ldac_n = ~ldac_n;
            clr_n = ($urandom % 20) != 0;
            if (($urandom % 32) == 0) bin_sel = ~bin_sel;
            if (($urandom % 16) == 0) gpio_in = 2'($urandom);
            step(v, w);
            compare_all("RND R3 R4 R6 R12");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule